// File: doc/BRIEF.md
# Indexed RGB Palette Lookup RAM

This block is a 256-entry colour table. Each entry holds 24 bits: one byte each of red, green and blue. A processor loads and inspects the table through a small byte-wide register window. The display pipeline reads it through a separate pixel port that turns an 8-bit colour index into three 8-bit colour components.

The processor picks a starting entry by writing the load-pointer register. It then pushes bytes into the single data register in red, green, blue order. A three-state phase machine (`PH_RED -> PH_GRN -> PH_BLU -> PH_RED`) tracks which byte comes next. On the blue byte the entry is written into the table as a whole, and the pointer moves on by one, wrapping from 255 to 0. Readback works the same way through its own fetch-pointer register and its own phase machine.

A pixel mask register is ANDed with every incoming pixel index before the lookup. The mask value 0xFF passes the index through unchanged. The pixel port is a registered read, and processor writes never stall it.

Top module: `pal_lut_top`

Register window, selected by `cpu_addr`:
- 0 is the load pointer.
- 1 is colour data.
- 2 is the pixel mask.
- 3 is the fetch pointer.

Phase machine transitions:
- `PH_RED -> PH_GRN` on a data access.
- `PH_GRN -> PH_BLU` on a data access.
- `PH_BLU -> PH_RED` on a data access, and the pointer advances by one.
- Any state goes to `PH_RED` when its pointer register is written.

## Requirements
- R1: While reset is held, `cpu_rdata`, `pix_red`, `pix_grn` and `pix_blu` are 0. After reset both pointers read 0, both phase machines are in `PH_RED`, and the mask (address 2) reads 0xFF.
- R2: Writing address 0 sets the entry that the following data writes fill, and reading address 0 returns that pointer.
- R3: Three writes to address 1 supply red, then green, then blue of one entry. The entry keeps its old contents at the pixel port until the blue byte is written, and then all three bytes change together.
- R4: After the blue byte, the load pointer advances by one and wraps from 255 to 0. Writing all 768 bytes from entry 0 leaves address 0 reading 0.
- R5: Writing address 3 sets the fetch pointer. Reads of address 1 then return red, green, blue in turn, and the fetch pointer advances by one after blue, wrapping from 255 to 0. Reading address 3 returns the fetch pointer.
- R6: Writing either pointer register returns its phase to `PH_RED`, so the next data access is a red byte, even in the middle of an entry.
- R7: The load and fetch paths keep separate pointers and phases. Reads of the data register between the bytes of a write sequence do not change which entry or which byte the next write goes to.
- R8: One clock after `pix_idx` is presented, `pix_red`, `pix_grn` and `pix_blu` show the entry at `pix_idx & mask`. A mask of 0xFF leaves the index unmasked.
- R9: `cpu_rdata` updates on the clock edge that samples `cpu_rd` and holds its value while `cpu_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select: 0 load pointer, 1 data, 2 mask, 3 fetch pointer |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, registered |
| pix_idx | input | 8 | Pixel colour index |
| pix_red | output | 8 | Red component of looked-up entry |
| pix_grn | output | 8 | Green component of looked-up entry |
| pix_blu | output | 8 | Blue component of looked-up entry |

## Verification
Register writes take effect on the clock edge that samples the strobe, so a pointer or the mask can be read back on the very next access. A read result appears on `cpu_rdata` one edge after `cpu_rd`. The pixel port also has one edge of latency, counted from the edge on which the index (and the table) is sampled. The bench drives every stimulus on a falling edge and samples every result on the following falling edge, which is half a period after the only register stage involved. For the partial-entry check it probes the pixel port after the green byte and again after the blue byte.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] grn;
        logic [7:0] blu;
    } rgb_t;

    localparam logic [1:0] REG_LOAD_PTR  = 2'd0;
    localparam logic [1:0] REG_DATA      = 2'd1;
    localparam logic [1:0] REG_MASK      = 2'd2;
    localparam logic [1:0] REG_FETCH_PTR = 2'd3;

endpackage

// File: rtl/pal_phase_seq.sv
// Entry pointer plus red/green/blue phase tracker, used once for each CPU path.
module pal_phase_seq
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase
);
    localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

    phase_e           phase_nx;
    logic [IDX_W-1:0] idx_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RED;
            idx   <= '0;
        end else begin
            phase <= phase_nx;
            idx   <= idx_nx;
        end
    end

    // next-state logic
    always_comb begin
        phase_nx = phase;
        idx_nx   = idx;
        if (load) begin
            phase_nx = PH_RED;
            idx_nx   = load_val;
        end else if (step) begin
            unique case (phase)
                PH_RED:  phase_nx = PH_GRN;
                PH_GRN:  phase_nx = PH_BLU;
                PH_BLU: begin
                    phase_nx = PH_RED;
                    idx_nx   = idx + 1'b1;
                end
                default: phase_nx = PH_RED;
            endcase
        end
    end

    assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && phase == PH_RED) |=> (phase == PH_GRN));

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && phase == PH_BLU && idx == IDX_LAST) |=> (idx == '0 && phase == PH_RED));

    assert_load_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase == PH_RED && idx == $past(load_val)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(idx) && $stable(phase)));

endmodule

// File: rtl/pal_lut_store.sv
// Colour table: whole-entry write port, asynchronous CPU read, registered pixel read.
module pal_lut_store
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rgb_t             wr_rgb,
    input  logic [IDX_W-1:0] cpu_idx,
    output rgb_t             cpu_rgb,
    input  logic [IDX_W-1:0] pix_idx,
    output rgb_t             pix_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_rgb;
    end

    assign cpu_rgb = mem[cpu_idx];

    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_rgb <= '0;
        else
            pix_rgb <= mem[pix_idx];
    end

endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [1:0]       cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [7:0]       pix_red,
    output logic [7:0]       pix_grn,
    output logic [7:0]       pix_blu
);
    localparam logic [IDX_W-1:0] MASK_RST = {IDX_W{1'b1}};

    logic             ld_load, ld_step, fe_load, fe_step;
    logic [IDX_W-1:0] ld_idx, fe_idx;
    phase_e           ld_phase, fe_phase;
    logic [7:0]       stage_red, stage_grn;
    logic [IDX_W-1:0] mask_q;
    logic             commit;
    rgb_t             cpu_rgb, pix_rgb;
    logic [7:0]       lane [3];
    logic [7:0]       fetch_byte;

    // register window decode
    assign ld_load = cpu_wr && cpu_addr == REG_LOAD_PTR;
    assign ld_step = cpu_wr && cpu_addr == REG_DATA;
    assign fe_load = cpu_wr && cpu_addr == REG_FETCH_PTR;
    assign fe_step = cpu_rd && cpu_addr == REG_DATA;
    assign commit  = ld_step && ld_phase == PH_BLU;

    pal_phase_seq #(.IDX_W(IDX_W)) u_load_seq (
        .clk(clk), .rst_n(rst_n), .load(ld_load), .load_val(cpu_wdata[IDX_W-1:0]),
        .step(ld_step), .idx(ld_idx), .phase(ld_phase)
    );

    pal_phase_seq #(.IDX_W(IDX_W)) u_fetch_seq (
        .clk(clk), .rst_n(rst_n), .load(fe_load), .load_val(cpu_wdata[IDX_W-1:0]),
        .step(fe_step), .idx(fe_idx), .phase(fe_phase)
    );

    // staging of red and green until blue completes the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_red <= '0;
            stage_grn <= '0;
            mask_q    <= MASK_RST;
        end else begin
            if (ld_step && ld_phase == PH_RED) stage_red <= cpu_wdata;
            if (ld_step && ld_phase == PH_GRN) stage_grn <= cpu_wdata;
            if (cpu_wr && cpu_addr == REG_MASK) mask_q <= cpu_wdata[IDX_W-1:0];
        end
    end

    pal_lut_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_idx(ld_idx),
        .wr_rgb('{red: stage_red, grn: stage_grn, blu: cpu_wdata}),
        .cpu_idx(fe_idx), .cpu_rgb(cpu_rgb),
        .pix_idx(pix_idx & mask_q), .pix_rgb(pix_rgb)
    );

    // colour lane selection by fetch phase
    for (genvar g = 0; g < 3; g++) begin : g_lane
        assign lane[g] = cpu_rgb[8*(2-g) +: 8];
    end

    always_comb begin
        unique case (fe_phase)
            PH_RED:  fetch_byte = lane[0];
            PH_GRN:  fetch_byte = lane[1];
            PH_BLU:  fetch_byte = lane[2];
            default: fetch_byte = lane[0];
        endcase
    end

    // read data output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_rd) begin
            unique case (cpu_addr)
                REG_LOAD_PTR:  cpu_rdata <= 8'(ld_idx);
                REG_DATA:      cpu_rdata <= fetch_byte;
                REG_MASK:      cpu_rdata <= 8'(mask_q);
                REG_FETCH_PTR: cpu_rdata <= 8'(fe_idx);
                default:       cpu_rdata <= '0;
            endcase
        end
    end

    assign pix_red = pix_rgb.red;
    assign pix_grn = pix_rgb.grn;
    assign pix_blu = pix_rgb.blu;

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata));

    assert_commit_on_blue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_step && ld_phase == PH_GRN) |=> (ld_phase == PH_BLU && $stable(ld_idx)));

endmodule

// File: tb/sim_pal_lut_top.sv
module sim_pal_lut_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] pix_idx = '0;
    logic [7:0] pix_red, pix_grn, pix_blu;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pal_lut_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_idx(pix_idx),
        .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
    );

    // entries: {index, red, green, blue}
    localparam logic [31:0] VEC [8] = '{
        32'h00_12_34_56, 32'h01_FF_00_80, 32'h7F_01_02_03, 32'h80_AA_55_AA,
        32'hFE_0F_F0_3C, 32'hFF_C3_3C_99, 32'h42_00_00_00, 32'h10_FF_FF_FF
    };

    function automatic logic [23:0] fill_val(input int i);
        return {8'(i), ~8'(i), 8'(i) ^ 8'h3C};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic put_entry(input logic [7:0] i, input logic [23:0] c);
        cpu_write(2'd0, i);
        cpu_write(2'd1, c[23:16]);
        cpu_write(2'd1, c[15:8]);
        cpu_write(2'd1, c[7:0]);
    endtask

    task automatic pix_look(input logic [7:0] i, output logic [23:0] c);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
        c = {pix_red, pix_grn, pix_blu};
    endtask

    task automatic fetch_entry(input logic [7:0] i, output logic [23:0] c);
        logic [7:0] r, g, b;
        cpu_write(2'd3, i);
        cpu_read(2'd1, r);
        cpu_read(2'd1, g);
        cpu_read(2'd1, b);
        c = {r, g, b};
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0]  rb;
        logic [23:0] c;

        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", 32'(cpu_rdata), 32'h0);
        check("R1 pixel in reset", 32'({pix_red, pix_grn, pix_blu}), 32'h0);
        rst_n = 1'b1;
        cpu_read(2'd0, rb); check("R1 load ptr", 32'(rb), 32'h0);
        cpu_read(2'd3, rb); check("R1 fetch ptr", 32'(rb), 32'h0);
        cpu_read(2'd2, rb); check("R1 mask", 32'(rb), 32'hFF);

        // table of vectors: R2 R3 R5 R8
        for (int k = 0; k < 8; k++) begin
            put_entry(VEC[k][31:24], VEC[k][23:0]);
            cpu_read(2'd0, rb);
            check("R4 ptr after entry", 32'(rb), 32'(8'(VEC[k][31:24] + 8'd1)));
        end
        for (int k = 0; k < 8; k++) begin
            pix_look(VEC[k][31:24], c);
            check("R8 pixel lookup", 32'(c), 32'(VEC[k][23:0]));
            fetch_entry(VEC[k][31:24], c);
            check("R5 readback", 32'(c), 32'(VEC[k][23:0]));
        end

        // R2: load pointer readback
        cpu_write(2'd0, 8'h5D);
        cpu_read(2'd0, rb); check("R2 load ptr", 32'(rb), 32'h5D);

        // R4: full fill from 0 wraps pointer to 0
        cpu_write(2'd0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            c = fill_val(i);
            cpu_write(2'd1, c[23:16]);
            cpu_write(2'd1, c[15:8]);
            cpu_write(2'd1, c[7:0]);
        end
        cpu_read(2'd0, rb); check("R4 wrap to 0", 32'(rb), 32'h0);
        pix_look(8'd255, c); check("R4 last entry", 32'(c), 32'(fill_val(255)));
        pix_look(8'd0, c);   check("R4 first entry", 32'(c), 32'(fill_val(0)));

        // R3: partial entry invisible until blue
        cpu_write(2'd0, 8'd7);
        cpu_write(2'd1, 8'hA1);
        cpu_write(2'd1, 8'hB2);
        pix_look(8'd7, c); check("R3 unchanged before blue", 32'(c), 32'(fill_val(7)));
        cpu_write(2'd1, 8'hC3);
        pix_look(8'd7, c); check("R3 after blue", 32'(c), 32'h00A1B2C3);

        // R6: rewriting pointer mid-entry restarts at red
        cpu_write(2'd0, 8'd9);
        cpu_write(2'd1, 8'h11);
        cpu_write(2'd0, 8'd9);
        cpu_write(2'd1, 8'h22);
        cpu_write(2'd1, 8'h33);
        cpu_write(2'd1, 8'h44);
        pix_look(8'd9, c); check("R6 load restart", 32'(c), 32'h00223344);
        cpu_read(2'd0, rb); check("R6 ptr after restart", 32'(rb), 32'd10);
        cpu_write(2'd3, 8'd9);
        cpu_read(2'd1, rb);
        cpu_write(2'd3, 8'd9);
        cpu_read(2'd1, rb); check("R6 fetch restart red", 32'(rb), 32'h22);

        // R7: interleaved readback does not disturb write sequence
        cpu_write(2'd0, 8'd20);
        cpu_write(2'd1, 8'h5A);
        fetch_entry(8'd5, c); check("R7 interleaved read", 32'(c), 32'(fill_val(5)));
        cpu_write(2'd1, 8'h6B);
        cpu_read(2'd1, rb); check("R7 fetch continues", 32'(rb), 32'(fill_val(6)) >> 16);
        cpu_write(2'd1, 8'h7C);
        pix_look(8'd20, c); check("R7 entry intact", 32'(c), 32'h005A6B7C);
        cpu_read(2'd0, rb); check("R7 load ptr", 32'(rb), 32'd21);

        // R5: fetch pointer wraps after blue of entry 255
        fetch_entry(8'd255, c); check("R5 fetch 255", 32'(c), 32'(fill_val(255)));
        cpu_read(2'd3, rb); check("R5 fetch wrap", 32'(rb), 32'h0);

        // R8: mask gates pixel index
        cpu_write(2'd2, 8'h0F);
        cpu_read(2'd2, rb); check("R8 mask readback", 32'(rb), 32'h0F);
        pix_look(8'hF7, c); check("R8 masked index", 32'(c), 32'h00A1B2C3);
        cpu_write(2'd2, 8'hFF);
        pix_look(8'hF7, c); check("R8 mask FF", 32'(c), 32'(fill_val(247)));

        // R9: rdata holds without a read strobe
        cpu_read(2'd2, rb);
        cpu_write(2'd2, 8'h33);
        repeat (2) @(negedge clk);
        check("R9 rdata hold", 32'(cpu_rdata), 32'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule